// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write dependences for the two ALU operands of a five-stage in-order integer pipeline. It takes the two source register numbers of the instruction now in the execute stage. It also takes the destination register number and write flag of each of the two older instructions still in flight: the one leaving execute and the one in write-back. For each operand it decides whether the register-file value is stale. When it is, it selects the newer result from one of the later pipeline registers.

The decision is made by comparing register numbers carried down the pipeline registers, with no scoreboard. When both older instructions target the same source, the more recent one wins. A match is ignored when the older instruction does not write a register, or when it targets register 0. The write-back candidate is the value that stage will really write: memory data for a load, the ALU result otherwise. The top level also holds the two operand multiplexers, so each resolved operand value appears next to its select code. Everything is combinational.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage forwards to a source, that operand's select is 2'b00 and the operand equals its register-file value.
- R2: When the execute/memory stage writes a nonzero register equal to a source, that operand's select is 2'b10 and the operand equals `exm_result`.
- R3: When only the memory/write-back stage writes a nonzero register equal to a source, that operand's select is 2'b01 and the operand equals the write-back value.
- R4: When both older stages would forward to the same source, the execute/memory stage wins (select 2'b10).
- R5: A stage whose write flag is low never causes forwarding, whatever its destination number.
- R6: A destination of register 0 never causes forwarding, even with the write flag high.
- R7: The write-back value is `mwb_mem_data` when `mwb_from_mem` is 1 and `mwb_result` when it is 0.
- R8: The two operands are resolved independently: operand B follows R1 to R7 using `src_b_idx` and `rf_b_val`, and both operands may forward in the same cycle, from the same or different stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | REG_AW | First source register number of the execute-stage instruction |
| src_b_idx | input | REG_AW | Second source register number of the execute-stage instruction |
| exm_dst | input | REG_AW | Destination register of the execute/memory stage instruction |
| exm_wr | input | 1 | Register write flag of the execute/memory stage instruction |
| mwb_dst | input | REG_AW | Destination register of the memory/write-back stage instruction |
| mwb_wr | input | 1 | Register write flag of the memory/write-back stage instruction |
| mwb_from_mem | input | 1 | Write-back source flag: 1 selects memory data, 0 the ALU result |
| rf_a_val | input | DATA_W | Register-file value read for operand A |
| rf_b_val | input | DATA_W | Register-file value read for operand B |
| exm_result | input | DATA_W | ALU result held in the execute/memory register |
| mwb_result | input | DATA_W | ALU result held in the memory/write-back register |
| mwb_mem_data | input | DATA_W | Load data held in the memory/write-back register |
| sel_a | output | 2 | Operand A select code (00 register file, 10 execute/memory, 01 write-back) |
| sel_b | output | 2 | Operand B select code, same encoding |
| opnd_a | output | DATA_W | Resolved operand A |
| opnd_b | output | DATA_W | Resolved operand B |

## Verification
Every result of this block is due in the same cycle as its stimulus, because there is no register between the inputs and the select codes or operands. The bench changes inputs just after a rising edge and reads the outputs at the next falling edge, half a period later. In a small configuration with 3-bit register numbers it sweeps every combination of source numbers, destination numbers, write flags and the write-back source flag. Expected select codes and operand values are worked out from the requirements. Each failure is tagged with the rule that applies to that vector, which can be no forwarding, forwarding from either stage, priority, a blocked write flag, register 0 or the load-data path.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Operand source select encoding; bit positions are decoded by the operand mux.
   typedef enum logic [1:0] {
      SEL_RF = 2'b00,
      SEL_MW = 2'b01,
      SEL_EX = 2'b10
   } fwd_sel_e;

   localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
   parameter int unsigned REG_AW    = 5,
   parameter bit          SKIP_ZERO = 1'b1
) (
   input  logic [REG_AW-1:0] src_idx,
   input  logic [REG_AW-1:0] dst_idx,
   input  logic              dst_wr,
   output logic              hit
);

   logic same_reg;
   assign same_reg = (src_idx == dst_idx);

   generate
      if (SKIP_ZERO) begin : g_zero_masked
         logic dst_live;
         assign dst_live = |dst_idx;
         assign hit      = dst_wr & same_reg & dst_live;
      end else begin : g_zero_plain
         assign hit = dst_wr & same_reg;
      end
   endgenerate

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
   import fwd_pkg::*;
(
   input  logic     ex_hit,
   input  logic     mw_hit,
   output fwd_sel_e sel
);

   always_comb begin
      if (ex_hit)      sel = SEL_EX;
      else if (mw_hit) sel = SEL_MW;
      else             sel = SEL_RF;
   end

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
   import fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] ex_val,
   input  logic [DATA_W-1:0] mw_val,
   output logic [DATA_W-1:0] opnd
);

   always_comb begin
      unique case (sel)
         SEL_EX:  opnd = ex_val;
         SEL_MW:  opnd = mw_val;
         default: opnd = rf_val;
      endcase
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW         = 5,
   parameter int unsigned DATA_W         = 32,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] src_a_idx,
   input  logic [REG_AW-1:0] src_b_idx,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              exm_wr,
   input  logic [REG_AW-1:0] mwb_dst,
   input  logic              mwb_wr,
   input  logic              mwb_from_mem,
   input  logic [DATA_W-1:0] rf_a_val,
   input  logic [DATA_W-1:0] rf_b_val,
   input  logic [DATA_W-1:0] exm_result,
   input  logic [DATA_W-1:0] mwb_result,
   input  logic [DATA_W-1:0] mwb_mem_data,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);

   localparam int unsigned NUM_REGS = 1 << REG_AW;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("fwd_unit: REG_AW out of range");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("fwd_unit: DATA_W must be positive");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("fwd_unit: register file too small");
      end
   endgenerate

   // Write-back candidate: the value the oldest stage will really write (R7)
   logic [DATA_W-1:0] wb_val;
   assign wb_val = mwb_from_mem ? mwb_mem_data : mwb_result;

   logic [REG_AW-1:0] src_idx [NUM_OPND];
   logic [DATA_W-1:0] rf_val  [NUM_OPND];
   fwd_sel_e          sel_v   [NUM_OPND];
   logic [DATA_W-1:0] opnd_v  [NUM_OPND];

   assign src_idx[0] = src_a_idx;
   assign src_idx[1] = src_b_idx;
   assign rf_val[0]  = rf_a_val;
   assign rf_val[1]  = rf_b_val;

   generate
      for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
         logic ex_hit;
         logic mw_hit;

         fwd_hit #(.REG_AW(REG_AW), .SKIP_ZERO(ZERO_REG_FIXED)) u_ex_hit (
            .src_idx (src_idx[i]),
            .dst_idx (exm_dst),
            .dst_wr  (exm_wr),
            .hit     (ex_hit)
         );

         fwd_hit #(.REG_AW(REG_AW), .SKIP_ZERO(ZERO_REG_FIXED)) u_mw_hit (
            .src_idx (src_idx[i]),
            .dst_idx (mwb_dst),
            .dst_wr  (mwb_wr),
            .hit     (mw_hit)
         );

         fwd_pick u_pick (
            .ex_hit (ex_hit),
            .mw_hit (mw_hit),
            .sel    (sel_v[i])
         );

         fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel    (sel_v[i]),
            .rf_val (rf_val[i]),
            .ex_val (exm_result),
            .mw_val (wb_val),
            .opnd   (opnd_v[i])
         );

         always_comb begin
            // R5
            if (sel_v[i] == SEL_EX)
               ex_wr_gate_chk: assert (exm_wr && exm_dst == src_idx[i]);
            // R5
            if (sel_v[i] == SEL_MW)
               mw_wr_gate_chk: assert (mwb_wr && mwb_dst == src_idx[i]);
            // R6
            if (ZERO_REG_FIXED && sel_v[i] != SEL_RF)
               zero_reg_chk: assert (src_idx[i] != '0);
            // R4
            if (ZERO_REG_FIXED && exm_wr && exm_dst == src_idx[i] && exm_dst != '0)
               ex_priority_chk: assert (sel_v[i] == SEL_EX);
            // R2
            if (sel_v[i] == SEL_EX)
               ex_value_chk: assert (opnd_v[i] == exm_result);
            // R7
            if (sel_v[i] == SEL_MW)
               wb_value_chk: assert (opnd_v[i] == (mwb_from_mem ? mwb_mem_data : mwb_result));
            // R1
            if (sel_v[i] == SEL_RF)
               rf_value_chk: assert (opnd_v[i] == rf_val[i]);
         end
      end
   endgenerate

   assign sel_a  = sel_v[0];
   assign sel_b  = sel_v[1];
   assign opnd_a = opnd_v[0];
   assign opnd_b = opnd_v[1];

endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;

   localparam int unsigned AW = 3;
   localparam int unsigned DW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] src_a, src_b, ex_dst, mw_dst;
   logic          ex_wr, mw_wr, mw_mem;
   logic [DW-1:0] rf_a, rf_b, ex_res, mw_res, mw_mem_d;
   logic [1:0]    sel_a, sel_b;
   logic [DW-1:0] opnd_a, opnd_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4ns clk = ~clk;   // 125 MHz

   fwd_unit #(.REG_AW(AW), .DATA_W(DW), .ZERO_REG_FIXED(1'b1)) u0 (
      .src_a_idx    (src_a),
      .src_b_idx    (src_b),
      .exm_dst      (ex_dst),
      .exm_wr       (ex_wr),
      .mwb_dst      (mw_dst),
      .mwb_wr       (mw_wr),
      .mwb_from_mem (mw_mem),
      .rf_a_val     (rf_a),
      .rf_b_val     (rf_b),
      .exm_result   (ex_res),
      .mwb_result   (mw_res),
      .mwb_mem_data (mw_mem_d),
      .sel_a        (sel_a),
      .sel_b        (sel_b),
      .opnd_a       (opnd_a),
      .opnd_b       (opnd_b)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected select from the rules: execute/memory first, then write-back, then file.
   function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
      if (ex_wr && ex_dst == s && ex_dst != 0) return 2'b10;
      if (mw_wr && mw_dst == s && mw_dst != 0) return 2'b01;
      return 2'b00;
   endfunction

   function automatic string rule_tag(input logic [AW-1:0] s);
      logic exh, mwh;
      exh = ex_wr && ex_dst == s && ex_dst != 0;
      mwh = mw_wr && mw_dst == s && mw_dst != 0;
      if (exh && mwh) return "R4";
      if (exh)        return "R2";
      if (mwh)        return mw_mem ? "R7" : "R3";
      if ((ex_dst == s && ex_wr) || (mw_dst == s && mw_wr)) return "R6";
      if (ex_dst == s || mw_dst == s) return "R5";
      return "R1";
   endfunction

   task automatic check_opnd(input string pfx, input logic [AW-1:0] s, input logic [DW-1:0] rf,
                             input logic [1:0] act_sel, input logic [DW-1:0] act_val);
      logic [1:0]    es;
      logic [DW-1:0] ev;
      string         t;
      es = exp_sel(s);
      t  = {pfx, rule_tag(s)};
      case (es)
         2'b10:   ev = ex_res;
         2'b01:   ev = mw_mem ? mw_mem_d : mw_res;
         default: ev = rf;
      endcase
      chk({t, " sel"}, {{(DW-2){1'b0}}, act_sel}, {{(DW-2){1'b0}}, es});
      chk({t, " val"}, act_val, ev);
   endtask

   initial begin
      src_a = '0; src_b = '0; ex_dst = '0; mw_dst = '0;
      ex_wr = 1'b0; mw_wr = 1'b0; mw_mem = 1'b0;
      rf_a = 16'h1111; rf_b = 16'h2222; ex_res = 16'h3333;
      mw_res = 16'h4444; mw_mem_d = 16'h5555;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: quiet inputs give register-file operands
      chk("R1 reset sel_a", {14'd0, sel_a}, 16'd0);
      chk("R1 reset opnd_a", opnd_a, 16'h1111);
      chk("R8 reset opnd_b", opnd_b, 16'h2222);
      rst = 1'b0;

      for (int v = 0; v < 32768; v++) begin
         @(posedge clk);
         src_a    = v[2:0];
         src_b    = v[5:3];
         ex_dst   = v[8:6];
         mw_dst   = v[11:9];
         ex_wr    = v[12];
         mw_wr    = v[13];
         mw_mem   = v[14];
         rf_a     = 16'h1000 | 16'(v[7:0]);
         rf_b     = 16'h2000 | 16'(v[11:4]);
         ex_res   = 16'h3000 | 16'(v[9:2]);
         mw_res   = 16'h4000 | 16'(v[13:6]);
         mw_mem_d = 16'h5000 | 16'(v[14:7]);
         @(negedge clk);
         check_opnd("",    src_a, rf_a, sel_a, opnd_a);
         check_opnd("R8/", src_b, rf_b, sel_b, opnd_b);
      end

      // R8: both operands forward at once from different stages
      @(posedge clk);
      src_a = 3'd4; src_b = 3'd5; ex_dst = 3'd4; mw_dst = 3'd5;
      ex_wr = 1'b1; mw_wr = 1'b1; mw_mem = 1'b1;
      @(negedge clk);
      chk("R8 dual sel_a", {14'd0, sel_a}, 16'd2);
      chk("R8 dual sel_b", {14'd0, sel_b}, 16'd1);
      chk("R8 dual opnd_b", opnd_b, mw_mem_d);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule